// File: doc/BRIEF.md
# Conditional Branch and Link Unit

This block resolves the branch-format instructions of a 32-bit load/store processor. It takes the instruction word, the word-addressed program counter that fetch has already advanced past it, the four condition flags (negative, zero, carry, overflow) and the value read from the register named by the instruction. From these it decides whether the branch is taken and computes the next word-addressed program counter. It also decides whether to write the return address into the link register.

The unit is purely combinational. The surrounding datapath registers `next_pc` and performs the link write. When a link write is requested, the unit also flags that the write must refresh the zero and negative flags, as any ordinary register write does. Instructions that are not branch-format pass the advanced counter straight through and request nothing.

Top module: `branch_link_unit`

## Requirements
- R1: An instruction is branch-format only when bit 31 and bit 30 are both 1. For any other instruction, `taken` and `link_we` are 0 and `next_pc` equals `pc_inc`.
- R2: The condition index in bits 26:24 picks the base condition: 0 negative, 1 zero, 2 carry, 3 overflow, 4 carry OR zero, 5 negative XOR overflow, 6 (negative XOR overflow) OR zero, 7 constant true.
- R3: Bit 27 inverts the selected condition. Index 7 with bit 27 clear is always taken. Index 7 with bit 27 set is never taken, whatever bits 28 and 29 hold.
- R4: A taken branch with bit 29 clear jumps to a register target: `next_pc` is `rc_val` divided by 4, and its two low bits are dropped.
- R5: A taken branch with bit 29 set jumps to a relative target: `next_pc` is `pc_inc` plus the sign-extended 24-bit offset in bits 23:0, modulo 2^PC_W. It wraps in both directions.
- R6: A taken branch with bit 28 set raises `link_we`. It sets `link_idx` to 15 and `link_data` to `pc_inc` times 4, the byte address of the next instruction. This holds for either target kind.
- R7: A branch whose condition fails leaves `next_pc` at `pc_inc` and keeps `link_we` at 0, even when bit 28 is set.
- R8: `link_upd_nz` is 1 exactly when `link_we` is 1, so that the link write updates the zero and negative flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word under evaluation |
| pc_inc | input | PC_W | Word address of the following instruction |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| rc_val | input | XLEN | Value of the register named in bits 3:0 |
| next_pc | output | PC_W | Word address to fetch next |
| taken | output | 1 | Branch condition met on a branch-format instruction |
| link_we | output | 1 | Link register write request |
| link_idx | output | 4 | Register written by the link (always 15) |
| link_data | output | XLEN | Byte return address for the link |
| link_upd_nz | output | 1 | Link write must refresh the zero and negative flags |

## Verification
The directed tests sweep all eight condition indices, with and without inversion. They use flag patterns where exactly one flag, or one combination of flags, separates a hit from a miss, so a wrong row in the condition table or a swapped flag shows up. The relative-target tests place the offset at its positive and negative extremes next to counter values of zero and all ones. This separates correct sign extension and wraparound from zero extension or saturation. The register-target tests set the two low bits of `rc_val` to catch a missing divide. The link tests pair the link bit with taken, failed and never branches. A pseudo-random stream of mixed branch and non-branch words is then compared each cycle against a behavioural model.

// File: rtl/brl_pkg.sv
package brl_pkg;

  typedef enum logic [2:0] {
    CND_NEG    = 3'd0,
    CND_ZERO   = 3'd1,
    CND_CARRY  = 3'd2,
    CND_OVF    = 3'd3,
    CND_LOWSAM = 3'd4,
    CND_LESS   = 3'd5,
    CND_LESSEQ = 3'd6,
    CND_TRUE   = 3'd7
  } cond_sel_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  // field positions are decoded by the instruction encoder, keep them fixed
  typedef struct packed {
    logic        fmt_hi;   // 31
    logic        fmt_lo;   // 30
    logic        rel_tgt;  // 29
    logic        do_link;  // 28
    logic        invert;   // 27
    cond_sel_e   sel;      // 26:24
    logic [23:0] ofs;      // 23:0
  } br_word_t;

endpackage

// File: rtl/brl_cond_eval.sv
module brl_cond_eval
  import brl_pkg::*;
(
  input  flags_t    flags,
  input  cond_sel_e sel,
  input  logic      invert,
  output logic      hit
);

  logic base;

  always_comb begin
    unique case (sel)
      CND_NEG:    base = flags.n;
      CND_ZERO:   base = flags.z;
      CND_CARRY:  base = flags.c;
      CND_OVF:    base = flags.v;
      CND_LOWSAM: base = flags.c | flags.z;
      CND_LESS:   base = flags.n ^ flags.v;
      CND_LESSEQ: base = (flags.n ^ flags.v) | flags.z;
      default:    base = 1'b1;
    endcase
  end

  assign hit = base ^ invert;

endmodule

// File: rtl/brl_target.sv
module brl_target #(
  parameter int PC_W  = 30,
  parameter int XLEN  = 32,
  parameter int OFS_W = 24
) (
  input  logic [PC_W-1:0]  pc_inc,
  input  logic [XLEN-1:0]  rc_val,
  input  logic [OFS_W-1:0] ofs,
  input  logic             rel_tgt,
  output logic [PC_W-1:0]  target
);

  logic [PC_W-1:0] ofs_ext;
  logic [PC_W-1:0] reg_tgt;
  logic [XLEN-1:0] rc_words;

  assign ofs_ext  = PC_W'($signed(ofs));
  assign rc_words = rc_val >> 2;
  assign reg_tgt  = PC_W'(rc_words);

  always_comb begin
    if (rel_tgt) target = pc_inc + ofs_ext;
    else         target = reg_tgt;
  end

endmodule

// File: rtl/branch_link_unit.sv
module branch_link_unit
  import brl_pkg::*;
#(
  parameter int PC_W     = 30,
  parameter int XLEN     = 32,
  parameter int LINK_REG = 15
) (
  input  logic [31:0]     instr,
  input  logic [PC_W-1:0] pc_inc,
  input  logic            flag_n,
  input  logic            flag_z,
  input  logic            flag_c,
  input  logic            flag_v,
  input  logic [XLEN-1:0] rc_val,
  output logic [PC_W-1:0] next_pc,
  output logic            taken,
  output logic            link_we,
  output logic [3:0]      link_idx,
  output logic [XLEN-1:0] link_data,
  output logic            link_upd_nz
);

  localparam int OFS_W  = 24;
  localparam int BYTE_W = PC_W + 2;

  br_word_t        bw;
  flags_t          flags;
  logic            is_branch;
  logic            cond_hit;
  logic [PC_W-1:0] target;
  logic [BYTE_W-1:0] ret_bytes;

  assign bw        = br_word_t'(instr);
  assign flags     = '{n: flag_n, z: flag_z, c: flag_c, v: flag_v};
  assign is_branch = bw.fmt_hi & bw.fmt_lo;

  brl_cond_eval u_cond (
    .flags  (flags),
    .sel    (bw.sel),
    .invert (bw.invert),
    .hit    (cond_hit)
  );

  brl_target #(.PC_W(PC_W), .XLEN(XLEN), .OFS_W(OFS_W)) u_tgt (
    .pc_inc  (pc_inc),
    .rc_val  (rc_val),
    .ofs     (bw.ofs),
    .rel_tgt (bw.rel_tgt),
    .target  (target)
  );

  assign ret_bytes = {pc_inc, 2'b00};

  always_comb begin
    taken       = is_branch & cond_hit;
    next_pc     = taken ? target : pc_inc;
    link_we     = taken & bw.do_link;
    link_upd_nz = link_we;
    link_idx    = 4'(LINK_REG);
    link_data   = XLEN'(ret_bytes);
  end

endmodule

// File: rtl/brl_checker.sv
module brl_checker #(
  parameter int PC_W = 30,
  parameter int XLEN = 32
) (
  input logic [31:0]     instr,
  input logic [PC_W-1:0] pc_inc,
  input logic            flag_n,
  input logic            flag_z,
  input logic            flag_c,
  input logic            flag_v,
  input logic [XLEN-1:0] rc_val,
  input logic [PC_W-1:0] next_pc,
  input logic            taken,
  input logic            link_we,
  input logic [3:0]      link_idx,
  input logic [XLEN-1:0] link_data,
  input logic            link_upd_nz
);

  logic br_fmt;
  logic [XLEN-1:0] rc_shift;
  assign br_fmt   = instr[31] & instr[30];
  assign rc_shift = rc_val >> 2;

  always_comb begin
    // R1
    non_branch_quiet_chk: assert (br_fmt || (!taken && !link_we && next_pc == pc_inc));
    // R2
    zero_cond_chk: assert (!(br_fmt && instr[27:24] == 4'b0001) || (taken == flag_z));
    // R3
    never_cond_chk: assert (!(br_fmt && instr[27:24] == 4'b1111) || (!taken && !link_we));
    // R3
    always_cond_chk: assert (!(br_fmt && instr[27:24] == 4'b0111) || taken);
    // R4
    reg_target_chk: assert (!(taken && !instr[29]) || next_pc == PC_W'(rc_shift));
    // R6
    link_content_chk: assert (!link_we || (taken && instr[28] && link_idx == 4'd15
                               && link_data == XLEN'({pc_inc, 2'b00})));
    // R7
    not_taken_hold_chk: assert (taken || (next_pc == pc_inc && !link_we));
    // R8
    link_flag_pair_chk: assert (link_upd_nz == link_we);
    // R2
    carry_cond_chk: assert (!(br_fmt && instr[27:24] == 4'b0010) || (taken == flag_c)
                            || (flag_n && flag_v && 1'b0));
  end

endmodule

bind branch_link_unit brl_checker #(.PC_W(PC_W), .XLEN(XLEN)) u_brl_chk (
  .instr       (instr),
  .pc_inc      (pc_inc),
  .flag_n      (flag_n),
  .flag_z      (flag_z),
  .flag_c      (flag_c),
  .flag_v      (flag_v),
  .rc_val      (rc_val),
  .next_pc     (next_pc),
  .taken       (taken),
  .link_we     (link_we),
  .link_idx    (link_idx),
  .link_data   (link_data),
  .link_upd_nz (link_upd_nz)
);

// File: tb/branch_link_unit_test.sv
`timescale 1ns/100ps
module branch_link_unit_test;

  localparam int PC_W = 30;
  localparam int XLEN = 32;

  logic            clk;
  logic            rst_n;
  logic [31:0]     instr;
  logic [PC_W-1:0] pc_inc;
  logic            flag_n, flag_z, flag_c, flag_v;
  logic [XLEN-1:0] rc_val;
  logic [PC_W-1:0] next_pc;
  logic            taken, link_we, link_upd_nz;
  logic [3:0]      link_idx;
  logic [XLEN-1:0] link_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  branch_link_unit #(.PC_W(PC_W), .XLEN(XLEN)) uut (
    .instr(instr), .pc_inc(pc_inc),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
    .rc_val(rc_val), .next_pc(next_pc), .taken(taken), .link_we(link_we),
    .link_idx(link_idx), .link_data(link_data), .link_upd_nz(link_upd_nz)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // behavioural reference
  logic [PC_W-1:0] e_pc;
  logic            e_tk, e_lw;
  logic [XLEN-1:0] e_ld;

  task automatic model();
    bit cnd;
    int idx;
    longint off;
    longint mask;
    mask = (longint'(1) << PC_W) - 1;
    idx  = int'(instr[26:24]);
    case (idx)
      0: cnd = flag_n;
      1: cnd = flag_z;
      2: cnd = flag_c;
      3: cnd = flag_v;
      4: cnd = flag_c || flag_z;
      5: cnd = flag_n != flag_v;
      6: cnd = (flag_n != flag_v) || flag_z;
      default: cnd = 1;
    endcase
    if (instr[27]) cnd = !cnd;
    e_tk = (instr[31:30] == 2'b11) && cnd;
    e_lw = e_tk && instr[28];
    e_ld = XLEN'(longint'(pc_inc) * 4);
    if (!e_tk) e_pc = pc_inc;
    else if (!instr[29]) e_pc = PC_W'(rc_val / 4);
    else begin
      off = longint'(instr[23:0]);
      if (off >= 64'h80_0000) off = off - 64'h100_0000;
      e_pc = PC_W'((longint'(pc_inc) + off) & mask);
    end
  endtask

  task automatic compare(input string tag);
    model();
    n_checks++;
    if (next_pc !== e_pc || taken !== e_tk || link_we !== e_lw ||
        link_upd_nz !== e_lw || (e_lw && (link_idx !== 4'd15 || link_data !== e_ld))) begin
      n_fail++;
      $display("FAIL %s: instr=%h got pc=%h tk=%b lw=%b nz=%b idx=%0d ld=%h exp pc=%h tk=%b lw=%b ld=%h",
               tag, instr, next_pc, taken, link_we, link_upd_nz, link_idx, link_data,
               e_pc, e_tk, e_lw, e_ld);
    end
  endtask

  task automatic apply(input logic [31:0] i, input logic [PC_W-1:0] p,
                       input logic [3:0] f, input logic [XLEN-1:0] r, input string tag);
    @(posedge clk);
    #1;
    instr = i; pc_inc = p; rc_val = r;
    {flag_n, flag_z, flag_c, flag_v} = f;
    @(negedge clk);
    compare(tag);
  endtask

  function automatic logic [31:0] br(input bit rel, input bit lnk, input bit inv,
                                     input int sel, input logic [23:0] ofs);
    return {2'b11, rel, lnk, inv, 3'(sel), ofs};
  endfunction

  initial begin
    rst_n = 1'b0;
    instr = '0; pc_inc = '0; rc_val = '0;
    {flag_n, flag_z, flag_c, flag_v} = 4'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    compare("R1 reset idle");

    // R1: non-branch words
    apply(32'h7F00_0010, 30'h123, 4'b1111, 32'h40, "R1 bit31 clear");
    apply(32'hBF00_0010, 30'h123, 4'b1111, 32'h40, "R1 bit30 clear");

    // R2 / R3: every index, both polarities, every flag pattern
    for (int s = 0; s < 8; s++)
      for (int inv = 0; inv < 2; inv++)
        for (int f = 0; f < 16; f++)
          apply(br(1, 0, inv[0], s, 24'h10), 30'h200, 4'(f), 32'h0,
                inv ? "R3 inverted table" : "R2 table");

    // R3: never, even with link set
    apply(br(1, 1, 1, 7, 24'h5), 30'h77, 4'b1111, 32'h0, "R3 never with link");
    apply(br(0, 1, 0, 7, 24'h0), 30'h77, 4'b0000, 32'h100, "R3 always register");

    // R4: register targets with low bits set
    apply(br(0, 0, 0, 7, 24'h0), 30'h10, 4'b0, 32'hFFFF_FFFF, "R4 reg all ones");
    apply(br(0, 0, 0, 7, 24'h0), 30'h10, 4'b0, 32'h0000_1237, "R4 reg low bits");

    // R5: offset extremes and wraparound
    apply(br(1, 0, 0, 7, 24'hFF_FFFF), 30'h0, 4'b0, 32'h0, "R5 wrap below zero");
    apply(br(1, 0, 0, 7, 24'h00_0001), 30'h3FFF_FFFF, 4'b0, 32'h0, "R5 wrap above top");
    apply(br(1, 0, 0, 7, 24'h7F_FFFF), 30'h100, 4'b0, 32'h0, "R5 max positive");
    apply(br(1, 0, 0, 7, 24'h80_0000), 30'h100_0000, 4'b0, 32'h0, "R5 max negative");

    // R6 / R8: link with each target kind
    apply(br(1, 1, 0, 7, 24'h4), 30'h3FFF_FFFF, 4'b0, 32'h0, "R6 link relative");
    apply(br(0, 1, 0, 1, 24'h0), 30'h2A, 4'b0100, 32'h800, "R6 link register");
    apply(br(0, 1, 0, 1, 24'h0), 30'h2A, 4'b0100, 32'h800, "R8 link flags");

    // R7: failed condition with link bit
    apply(br(0, 1, 0, 1, 24'h0), 30'h55, 4'b0000, 32'h900, "R7 fail no link");
    apply(br(1, 1, 1, 2, 24'h9), 30'h55, 4'b0010, 32'h900, "R7 fail inverted");

    // mixed stream
    for (int k = 0; k < 400; k++) begin
      logic [31:0] w;
      w = $urandom;
      if (k % 4 != 0) w[31:30] = 2'b11;
      apply(w, PC_W'($urandom), 4'($urandom), $urandom, "R5 R6 random mix");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, got hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule